// File: doc/BRIEF.md
# Dual-Topology LFSR Pattern Generator

This block is an N-stage linear feedback shift register that produces pseudo-random test patterns for a circuit under test. At elaboration, a parameter selects one of two wirings for the same characteristic polynomial. The first is the shift-and-fold form, where a single XOR tree at the top stage combines the tapped bits. The second is the distributed form, where XOR gates sit between stages and are driven by the top bit. A second parameter holds the polynomial coefficient vector `TAPS`. Bit i of `TAPS` holds h_i for i from 1 to N-1. The constant terms 1 and x^N are implied, so bit 0 is not used.

A controller seeds the register with `load` and `seed`, then advances it one pattern per cycle while `en` is high. The N-bit pattern is presented on `state`, with bit i holding stage X_i. An all-zero register can never leave that state, so a zero seed is replaced by the value with only X_0 set. The `lockup` output flags the all-zero state combinationally.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes the value with only bit 0 set (X_0 = 1), and `lockup` reads 0.
- R2: When `load` is high with a nonzero `seed`, `state` equals that seed after the next rising edge.
- R3: When `load` is high with `seed` all zeros, `state` becomes the value with only bit 0 set after the next rising edge.
- R4: With `load` and `en` both low, `state` keeps its value across a rising edge.
- R5: In the external topology, an enabled step moves X_{i+1} into X_i for i < N-1. It also sets X_{N-1} to X_0 XOR the XOR of h_i·X_i over i = 1..N-1. For N = 3 and taps h1 = 1, starting from state 3'b001, this gives 3'b100, 3'b010, 3'b101, 3'b110, 3'b111, 3'b011, and then 3'b001 again.
- R6: In the internal topology, an enabled step moves X_{N-1} into X_0 and sets X_i to X_{i-1} XOR (h_i AND X_{N-1}) for i ≥ 1. This equals multiplying the state polynomial by x modulo the characteristic polynomial.
- R7: With a primitive polynomial, either topology returns to its seed after exactly 2^N - 1 enabled steps and never earlier. Within that period, the all-ones pattern appears exactly once.
- R8: `lockup` is high exactly when `state` is all zeros. No sequence of loads, including zero seeds, and no sequence of steps makes it rise.
- R9: When `load` and `en` are high in the same cycle, the load wins: `state` becomes the seed, not the seed's successor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Replace the register with the seed (takes priority over `en`) |
| seed | input | WIDTH | Seed value, bit i is X_i |
| state | output | WIDTH | Current pattern, bit i is X_i |
| lockup | output | 1 | High when the register holds all zeros |

## Verification
Seeding and stepping compete in any cycle where `load` and `en` are both high. The bench raises them together, both with a nonzero seed and with an all-zero seed. The result is judged correct only if the next pattern equals the (substituted) seed rather than its successor. The following enabled step must then continue the sequence from that seed. The same collision is driven into both topologies at once, because their successors differ and so a wrong priority would show in either one.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // Elaboration-time choice of feedback wiring
  typedef enum logic {
    TOPO_EXTERNAL = 1'b0,  // single XOR tree feeding the top stage
    TOPO_INTERNAL = 1'b1   // XOR gates between stages, driven by the top stage
  } topo_e;

endpackage

// File: rtl/lfsr_zero_detect.sv
module lfsr_zero_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             is_zero
);

  assign is_zero = ~|vec;

endmodule

// File: rtl/lfsr_ext_next.sv
// Shift-and-fold successor: stages shift toward X0, feedback lands in X[N-1]
module lfsr_ext_next #(
  parameter int unsigned     WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 'h70
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH-1:0] fold_terms;

  // X0 always participates; other stages only where the coefficient is set
  assign fold_terms[0] = cur[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_terms
    assign fold_terms[i] = TAPS[i] & cur[i];
  end

  for (genvar i = 0; i < WIDTH - 1; i++) begin : g_shift
    assign nxt[i] = cur[i+1];
  end

  assign nxt[WIDTH-1] = ^fold_terms;

endmodule

// File: rtl/lfsr_int_next.sv
// Distributed successor: multiply by x, reduce by the characteristic polynomial
module lfsr_int_next #(
  parameter int unsigned     WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 'h70
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  logic carry_out;

  assign carry_out = cur[WIDTH-1];
  assign nxt[0]    = carry_out;

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    if (TAPS[i]) begin : g_xor
      assign nxt[i] = cur[i-1] ^ carry_out;
    end else begin : g_wire
      assign nxt[i] = cur[i-1];
    end
  end

endmodule

// File: rtl/lfsr_pattern_gen.sv
module lfsr_pattern_gen #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 'h70,  // h_i in bit i; default x^8+x^6+x^5+x^4+1
  parameter lfsr_pkg::topo_e  TOPO  = lfsr_pkg::TOPO_EXTERNAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state,
  output logic             lockup
);

  localparam logic [WIDTH-1:0] SAFE_SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] seed_eff;
  logic             seed_is_zero;
  logic             take_seed;   // named event: seeding this cycle
  logic             advance;     // named event: stepping this cycle

  assign take_seed = load;
  assign advance   = en & ~load;

  lfsr_zero_detect #(.WIDTH(WIDTH)) u_seed_zero (
    .vec     (seed),
    .is_zero (seed_is_zero)
  );

  assign seed_eff = seed_is_zero ? SAFE_SEED : seed;

  if (TOPO == lfsr_pkg::TOPO_EXTERNAL) begin : g_ext
    lfsr_ext_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
      .cur (state_q),
      .nxt (step_val)
    );
  end else begin : g_int
    lfsr_int_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
      .cur (state_q),
      .nxt (step_val)
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            state_q <= SAFE_SEED;
    else if (take_seed) state_q <= seed_eff;
    else if (advance)   state_q <= step_val;
  end

  lfsr_zero_detect #(.WIDTH(WIDTH)) u_state_zero (
    .vec     (state_q),
    .is_zero (lockup)
  );

  assign state = state_q;

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state));

  // R2
  seed_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (seed != '0)) |=> (state == $past(seed)));

  // R3
  zero_seed_subst_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (seed == '0)) |=> (state == SAFE_SEED));

  // R8
  never_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !lockup);

  if (TOPO == lfsr_pkg::TOPO_EXTERNAL) begin : g_ext_chk
    // R5
    ext_shift_down_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !load) |=> (state[WIDTH-2:0] == $past(state[WIDTH-1:1])));
  end else begin : g_int_chk
    // R6
    int_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
      (en && !load) |=> (state[0] == $past(state[WIDTH-1])));
  end

endmodule

// File: tb/lfsr_pattern_gen_tb.sv
module lfsr_pattern_gen_tb;

  logic clk = 1'b0;
  logic rst, en, load;
  logic [2:0] seed3;
  logic [7:0] seed8;
  logic [2:0] st_e3, st_i3;
  logic [7:0] st_e8, st_i8;
  logic lk_e3, lk_i3, lk_e8, lk_i8;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] TAPS3 = 3'b010;     // 1 + x + x^3
  localparam logic [7:0] TAPS8 = 8'b0111_0000; // 1 + x^4 + x^5 + x^6 + x^8

  always #10 clk = ~clk;  // 50 MHz

  lfsr_pattern_gen #(.WIDTH(8), .TAPS(TAPS8), .TOPO(lfsr_pkg::TOPO_EXTERNAL)) u_dut (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed8), .state(st_e8), .lockup(lk_e8));
  lfsr_pattern_gen #(.WIDTH(8), .TAPS(TAPS8), .TOPO(lfsr_pkg::TOPO_INTERNAL)) u_dut_i8 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed8), .state(st_i8), .lockup(lk_i8));
  lfsr_pattern_gen #(.WIDTH(3), .TAPS(TAPS3), .TOPO(lfsr_pkg::TOPO_EXTERNAL)) u_dut_e3 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed3), .state(st_e3), .lockup(lk_e3));
  lfsr_pattern_gen #(.WIDTH(3), .TAPS(TAPS3), .TOPO(lfsr_pkg::TOPO_INTERNAL)) u_dut_i3 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed3), .state(st_i3), .lockup(lk_i3));

  // {load, en, seed[2:0], expected external 3-bit state}
  localparam int NVEC = 12;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 3'b001, 3'b001},  // R2 seed
    {1'b0, 1'b1, 3'b000, 3'b100},  // R5 sequence
    {1'b0, 1'b1, 3'b000, 3'b010},
    {1'b0, 1'b1, 3'b000, 3'b101},
    {1'b0, 1'b1, 3'b000, 3'b110},
    {1'b0, 1'b1, 3'b000, 3'b111},
    {1'b0, 1'b1, 3'b000, 3'b011},
    {1'b0, 1'b1, 3'b000, 3'b001},  // back to seed
    {1'b0, 1'b0, 3'b000, 3'b001},  // R4 hold
    {1'b1, 1'b0, 3'b000, 3'b001},  // R3 zero seed
    {1'b1, 1'b1, 3'b110, 3'b110},  // R9 load beats enable
    {1'b0, 1'b1, 3'b000, 3'b111}
  };

  // Bench model: shift toward bit 0, parity of tapped bits into the top
  function automatic logic [7:0] m_ext(input logic [7:0] s, input logic [7:0] taps, input int w);
    logic [7:0] r;
    logic fb;
    fb = s[0];
    for (int i = 1; i < w; i++) fb = fb ^ (taps[i] & s[i]);
    r = s >> 1;
    r[w-1] = fb;
    return r;
  endfunction

  // Bench model: polynomial times x, reduced modulo f(x)
  function automatic logic [7:0] m_int(input logic [7:0] s, input logic [7:0] taps, input int w);
    logic [7:0] mask, r;
    mask = 8'((16'd1 << w) - 16'd1);
    r = (s << 1) & mask;
    if (s[w-1]) r = r ^ ((taps | 8'd1) & mask);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [7:0] mi3, me8, mi8;

  task automatic model_update(input logic ld, input logic e, input logic [2:0] s3, input logic [7:0] s8);
    if (ld) begin
      mi3 = (s3 == 3'd0) ? 8'd1 : {5'd0, s3};
      me8 = (s8 == 8'd0) ? 8'd1 : s8;
      mi8 = me8;
    end else if (e) begin
      mi3 = m_int(mi3, {5'd0, TAPS3}, 3);
      me8 = m_ext(me8, TAPS8, 8);
      mi8 = m_int(mi8, TAPS8, 8);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ones_e, ones_i, early_e, early_i;
    rst = 1'b1; en = 1'b0; load = 1'b0; seed3 = '0; seed8 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(st_e8 == 8'd1 && st_i8 == 8'd1, "R1 reset 8-bit", st_e8, 8'd1);
    chk({5'd0, st_e3} == 8'd1 && {5'd0, st_i3} == 8'd1, "R1 reset 3-bit", {5'd0, st_e3}, 8'd1);
    chk(!lk_e8 && !lk_i8 && !lk_e3 && !lk_i3, "R1 lockup low", {4'd0, lk_e8, lk_i8, lk_e3, lk_i3}, 8'd0);

    mi3 = 8'd1; me8 = 8'd1; mi8 = 8'd1;

    // Vector walk: external 3-bit against table, others against models
    for (int k = 0; k < NVEC; k++) begin
      load  = VEC[k][7];
      en    = VEC[k][6];
      seed3 = VEC[k][5:3];
      seed8 = {5'd0, VEC[k][5:3]} ^ 8'h00;
      model_update(load, en, seed3, seed8);
      @(negedge clk);
      chk(st_e3 == VEC[k][2:0], "R5/R2/R3/R4/R9 ext3 vector", {5'd0, st_e3}, {5'd0, VEC[k][2:0]});
      chk({5'd0, st_i3} == mi3, "R6 int3 step", {5'd0, st_i3}, mi3);
      chk(st_e8 == me8, "R5 ext8 step", st_e8, me8);
      chk(st_i8 == mi8, "R6 int8 step", st_i8, mi8);
    end

    // R9 with zero seed and enable together, then continue one step
    load = 1'b1; en = 1'b1; seed3 = 3'd0; seed8 = 8'd0;
    model_update(1'b1, 1'b1, 3'd0, 8'd0);
    @(negedge clk);
    chk(st_e8 == 8'd1 && st_i8 == 8'd1, "R9 zero seed with enable 8-bit", st_e8, 8'd1);
    chk(st_e3 == 3'b001, "R9 R3 zero seed with enable 3-bit", {5'd0, st_e3}, 8'd1);
    load = 1'b0;
    model_update(1'b0, 1'b1, 3'd0, 8'd0);
    @(negedge clk);
    chk(st_e3 == 3'b100, "R9 continue after collision ext3", {5'd0, st_e3}, 8'h04);
    chk(st_i8 == mi8, "R9 continue after collision int8", st_i8, mi8);

    // R7 full period for 8-bit, both topologies
    load = 1'b1; en = 1'b0; seed8 = 8'hA5; seed3 = 3'b011;
    @(negedge clk);
    chk(st_e8 == 8'hA5 && st_i8 == 8'hA5, "R2 seed 8-bit", st_e8, 8'hA5);
    load = 1'b0; en = 1'b1;
    me8 = 8'hA5; mi8 = 8'hA5;
    ones_e = 0; ones_i = 0; early_e = 0; early_i = 0;
    for (int s = 1; s <= 255; s++) begin
      me8 = m_ext(me8, TAPS8, 8);
      mi8 = m_int(mi8, TAPS8, 8);
      @(negedge clk);
      if (st_e8 != me8) chk(1'b0, "R5 ext8 period step", st_e8, me8);
      if (st_i8 != mi8) chk(1'b0, "R6 int8 period step", st_i8, mi8);
      if (lk_e8 || lk_i8 || lk_e3 || lk_i3) chk(1'b0, "R8 lockup rose", 8'd1, 8'd0);
      if (st_e8 == 8'hFF) ones_e++;
      if (st_i8 == 8'hFF) ones_i++;
      if (s < 255 && st_e8 == 8'hA5) early_e++;
      if (s < 255 && st_i8 == 8'hA5) early_i++;
    end
    en = 1'b0;
    chk(st_e8 == 8'hA5, "R7 ext8 returns after 255", st_e8, 8'hA5);
    chk(st_i8 == 8'hA5, "R7 int8 returns after 255", st_i8, 8'hA5);
    chk(early_e == 0 && early_i == 0, "R7 no early repeat", 8'(early_e + early_i), 8'd0);
    chk(ones_e == 1, "R7 ext8 all-ones once", 8'(ones_e), 8'd1);
    chk(ones_i == 1, "R7 int8 all-ones once", 8'(ones_i), 8'd1);
    chk(!lk_e8 && !lk_i8 && !lk_e3 && !lk_i3, "R8 lockup low after run", {4'd0, lk_e8, lk_i8, lk_e3, lk_i3}, 8'd0);

    // R4 hold on 8-bit
    @(negedge clk);
    chk(st_e8 == 8'hA5 && st_i8 == 8'hA5, "R4 hold 8-bit", st_i8, 8'hA5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule